// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Nibble-Packed Flags

This block is the arithmetic and logic unit of a small accumulator CPU. Each cycle it takes the accumulator value, a second operand, the current flag byte and a 4-bit operation code. It returns an 8-bit result, an updated flag byte and a write-enable bit that tells the register file whether to store the result. The core is purely combinational. Its outputs are captured in one register stage, so every operation presented before a rising edge shows its outputs after that edge.

The flag byte keeps its four flags in the upper nibble: zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. The lower nibble always reads zero. Half-carry follows the operation class: carry out of bit 3 for additions, borrow out of bit 3 for subtractions, and low-nibble tests for increment and decrement.

Increment and decrement read their operand from the second input rather than the accumulator. Any register can therefore be stepped in place.

Top module: `acc_alu8`

## Requirements
- R1: Flag byte layout is Z=bit 7, N=bit 6, H=bit 5, C=bit 4, and bits 3..0 of the output flag byte are always 0. Outputs are registered with one cycle of latency. While rst_n is low, result, flags and write enable are all 0.
- R2: Code 0 (add) returns acc+opnd mod 256. It clears N, sets H on a carry out of bit 3, sets C on a carry out of bit 7, and sets Z when the result is 0.
- R3: Code 1 (add with carry) and code 3 (subtract with carry) first form b = (opnd + C_in) mod 256, then behave exactly as code 0 and code 2 with b. For example, opnd 0xFF with C_in 1 acts as operand 0.
- R4: Code 2 (subtract) returns acc−opnd mod 256. It sets N, sets H when acc[3:0] < opnd[3:0], sets C when acc < opnd, and sets Z on a zero result.
- R5: Code 4 (compare) produces the same flags as subtract. The result bus carries the difference, and the write enable is 0.
- R6: Code 5 (AND) sets H and clears N and C. Code 6 (OR) and code 7 (XOR) clear N, H and C. All three set Z from the result.
- R7: Code 8 (increment) returns opnd+1 mod 256. It keeps C, clears N, sets H when result[3:0] is 0, and sets Z on a zero result.
- R8: Code 9 (decrement) returns opnd−1 mod 256. It keeps C, sets N, sets H when result[3:0] is 0xF, and sets Z on a zero result.
- R9: Code 10 (complement) returns ~acc with write enable 1. It sets N and H and keeps Z and C.
- R10: Code 11 (set carry) sets C, and code 12 (complement carry) inverts C. Both clear N and H, keep Z, return acc on the result bus, and drive write enable 0.
- R11: Codes 13 to 15 leave the flags unchanged except that the low nibble is cleared. They return acc on the result bus and drive write enable 0.
- R12: Write enable is 1 for codes 0 to 3 and 5 to 10, and 0 for all other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand; source for increment and decrement |
| flags_in | input | 8 | Current flag byte |
| res_q | output | 8 | Registered result |
| flags_q | output | 8 | Registered new flag byte |
| we_q | output | 1 | Registered accumulator/register write enable |

## Verification
The embedded properties check four things on every cycle after reset:
- The low nibble of the flag byte stays clear.
- Compare, the carry operations and the reserved codes never raise the write enable.
- Increment and decrement carry the incoming C through.
- Complement keeps Z and C, and every result-producing operation reports Z exactly when its result is zero.

The bench scenarios are needed to show the arithmetic values themselves: nibble and byte carries and borrows, the truncation of operand plus carry at 0xFF, and the wraparound at 0x00 and 0xFF for increment and decrement. These are compared against an integer model over directed corners and random operations.

// File: rtl/acc_alu8.sv
module acc_alu8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] flags_in,
  output logic [7:0] res_q,
  output logic [7:0] flags_q,
  output logic       we_q
);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_AND = 4'd5;
  localparam logic [3:0] OP_OR  = 4'd6;
  localparam logic [3:0] OP_XOR = 4'd7;
  localparam logic [3:0] OP_INC = 4'd8;
  localparam logic [3:0] OP_DEC = 4'd9;
  localparam logic [3:0] OP_CPL = 4'd10;
  localparam logic [3:0] OP_SCF = 4'd11;
  localparam logic [3:0] OP_CCF = 4'd12;

  logic       cin;
  logic [7:0] b_eff;
  logic [8:0] add_w, sub_w;
  logic [4:0] add_lo;
  logic       sub_hb;
  logic [7:0] inc_v, dec_v;

  assign cin    = flags_in[4] & ((op_sel == OP_ADC) | (op_sel == OP_SBC));
  assign b_eff  = opnd_in + {7'd0, cin};
  assign add_w  = {1'b0, acc_in} + {1'b0, b_eff};
  assign add_lo = {1'b0, acc_in[3:0]} + {1'b0, b_eff[3:0]};
  assign sub_w  = {1'b0, acc_in} - {1'b0, b_eff};
  assign sub_hb = acc_in[3:0] < b_eff[3:0];
  assign inc_v  = opnd_in + 8'd1;
  assign dec_v  = opnd_in - 8'd1;

  logic [7:0] res_n;
  logic       zf, nf, hf, cf, we_n;

  always_comb begin
    res_n = acc_in;
    zf    = flags_in[7];
    nf    = flags_in[6];
    hf    = flags_in[5];
    cf    = flags_in[4];
    we_n  = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADC: begin
        res_n = add_w[7:0];
        nf = 1'b0; hf = add_lo[4]; cf = add_w[8];
        zf = (add_w[7:0] == 8'd0); we_n = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        res_n = sub_w[7:0];
        nf = 1'b1; hf = sub_hb; cf = sub_w[8];
        zf = (sub_w[7:0] == 8'd0); we_n = (op_sel != OP_CMP);
      end
      OP_AND: begin
        res_n = acc_in & opnd_in;
        nf = 1'b0; hf = 1'b1; cf = 1'b0;
        zf = ((acc_in & opnd_in) == 8'd0); we_n = 1'b1;
      end
      OP_OR: begin
        res_n = acc_in | opnd_in;
        nf = 1'b0; hf = 1'b0; cf = 1'b0;
        zf = ((acc_in | opnd_in) == 8'd0); we_n = 1'b1;
      end
      OP_XOR: begin
        res_n = acc_in ^ opnd_in;
        nf = 1'b0; hf = 1'b0; cf = 1'b0;
        zf = ((acc_in ^ opnd_in) == 8'd0); we_n = 1'b1;
      end
      OP_INC: begin
        res_n = inc_v;
        nf = 1'b0; hf = (inc_v[3:0] == 4'h0);
        zf = (inc_v == 8'd0); we_n = 1'b1;
      end
      OP_DEC: begin
        res_n = dec_v;
        nf = 1'b1; hf = (dec_v[3:0] == 4'hF);
        zf = (dec_v == 8'd0); we_n = 1'b1;
      end
      OP_CPL: begin
        res_n = ~acc_in;
        nf = 1'b1; hf = 1'b1; we_n = 1'b1;
      end
      OP_SCF: begin
        nf = 1'b0; hf = 1'b0; cf = 1'b1;
      end
      OP_CCF: begin
        nf = 1'b0; hf = 1'b0; cf = ~flags_in[4];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= 8'd0;
      flags_q <= 8'd0;
      we_q    <= 1'b0;
    end else begin
      res_q   <= res_n;
      flags_q <= {zf, nf, hf, cf, 4'b0000};
      we_q    <= we_n;
    end
  end

  logic live_q;
  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> flags_q[3:0] == 4'd0); // R1
  AST_NO_WRITE_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(op_sel) == OP_CMP) |-> !we_q); // R5
  AST_NO_WRITE_CARRYOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(op_sel) >= OP_SCF) |-> !we_q); // R10
  AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && ($past(op_sel) == OP_INC || $past(op_sel) == OP_DEC))
      |-> flags_q[4] == $past(flags_in[4])); // R7
  AST_CPL_KEEP_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(op_sel) == OP_CPL)
      |-> (flags_q[7] == $past(flags_in[7]) && flags_q[4] == $past(flags_in[4]))); // R9
  AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(op_sel) <= OP_DEC) |-> flags_q[7] == (res_q == 8'd0)); // R6
  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (live_q && $past(op_sel) <= OP_CPL && $past(op_sel) != OP_CMP)); // R12

endmodule

// File: tb/acc_alu8_tb_top.sv
module acc_alu8_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0, flags_in = 8'd0;
  logic [7:0] res_q, flags_q;
  logic       we_q;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [16:0] exp_q[$];
  string       req_q[$];

  always #(CLK_P/2) clk = ~clk;

  acc_alu8 dut_i (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .acc_in(acc_in),
    .opnd_in(opnd_in), .flags_in(flags_in),
    .res_q(res_q), .flags_q(flags_q), .we_q(we_q)
  );

  function automatic string req_of(int op);
    case (op)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R3";
      4: return "R5";  5, 6, 7: return "R6";  8: return "R7";  9: return "R8";
      10: return "R9"; 11, 12: return "R10";
      default: return "R11";
    endcase
  endfunction

  // returns {we, flags, result}
  function automatic logic [16:0] model(int op, int a, int b, int f);
    int z = (f >> 7) & 1, n = (f >> 6) & 1, h = (f >> 5) & 1, c = (f >> 4) & 1;
    int r = a, w = 0, bb, t;
    case (op)
      0, 1: begin // R2 R3
        bb = (op == 1) ? (b + c) % 256 : b;
        t = a + bb; r = t % 256;
        n = 0; h = ((a % 16) + (bb % 16)) > 15 ? 1 : 0; c = t > 255 ? 1 : 0;
        z = (r == 0); w = 1;
      end
      2, 3, 4: begin // R4 R3 R5
        bb = (op == 3) ? (b + c) % 256 : b;
        r = (a - bb + 256) % 256;
        n = 1; h = (a % 16) < (bb % 16) ? 1 : 0; c = a < bb ? 1 : 0;
        z = (r == 0); w = (op != 4);
      end
      5: begin r = a & b; n = 0; h = 1; c = 0; z = (r == 0); w = 1; end // R6
      6: begin r = a | b; n = 0; h = 0; c = 0; z = (r == 0); w = 1; end
      7: begin r = a ^ b; n = 0; h = 0; c = 0; z = (r == 0); w = 1; end
      8: begin r = (b + 1) % 256; n = 0; h = (r % 16 == 0); z = (r == 0); w = 1; end // R7
      9: begin r = (b + 255) % 256; n = 1; h = (r % 16 == 15); z = (r == 0); w = 1; end // R8
      10: begin r = 255 - a; n = 1; h = 1; w = 1; end // R9
      11: begin n = 0; h = 0; c = 1; end // R10
      12: begin n = 0; h = 0; c = 1 - c; end
      default: ; // R11
    endcase
    return {w[0], z[0], n[0], h[0], c[0], 4'b0000, r[7:0]};
  endfunction

  task automatic check_pending();
    logic [16:0] e;
    string rq;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    rq = req_q.pop_front();
    n_cmp++;
    if ({we_q, flags_q, res_q} !== e) begin
      n_bad++;
      $display("FAIL %s%s (R1 layout): got we=%0b flags=%02h res=%02h exp we=%0b flags=%02h res=%02h",
               rq, (we_q !== e[16]) ? "/R12" : "", we_q, flags_q, res_q, e[16], e[15:8], e[7:0]);
    end
  endtask

  task automatic apply(int op, int a, int b, int f);
    @(negedge clk);
    check_pending();
    op_sel = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f[7:0];
    exp_q.push_back(model(op, a, b, f));
    req_q.push_back(req_of(op));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    op_sel = 4'd2; acc_in = 8'h00; opnd_in = 8'h01; flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    n_cmp++; // R1 reset state
    if ({we_q, flags_q, res_q} !== 17'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got we=%0b flags=%02h res=%02h exp 0/00/00", we_q, flags_q, res_q);
    end
    rst_n = 1'b1;
    // directed corners
    apply(0, 8'h0F, 8'h01, 8'h00);  // R2 half carry
    apply(0, 8'hF0, 8'h10, 8'h00);  // R2 carry and zero
    apply(0, 8'h12, 8'h34, 8'hFF);  // R2 and R1 low nibble cleared
    apply(1, 8'h10, 8'hFF, 8'h10);  // R3 operand truncates to 0
    apply(1, 8'h0E, 8'h01, 8'h10);  // R3 carry in gives half carry
    apply(3, 8'h05, 8'hFF, 8'h10);  // R3 subtract of truncated 0
    apply(3, 8'h05, 8'h04, 8'h10);  // R3 zero result
    apply(2, 8'h10, 8'h01, 8'h00);  // R4 half borrow
    apply(2, 8'h01, 8'h02, 8'h00);  // R4 borrow
    apply(2, 8'h33, 8'h33, 8'h00);  // R4 zero
    apply(4, 8'h40, 8'h40, 8'h00);  // R5 compare equal, no write
    apply(4, 8'h00, 8'h80, 8'h80);  // R5 compare borrow
    apply(5, 8'hF0, 8'h0F, 8'h10);  // R6 AND zero
    apply(6, 8'h00, 8'h00, 8'hF0);  // R6 OR zero
    apply(7, 8'hAA, 8'hAA, 8'h30);  // R6 XOR zero
    apply(8, 8'h00, 8'hFF, 8'h10);  // R7 wrap keeps carry
    apply(8, 8'h00, 8'h0F, 8'h00);  // R7 half
    apply(9, 8'h00, 8'h00, 8'h10);  // R8 wrap
    apply(9, 8'h00, 8'h01, 8'h00);  // R8 zero
    apply(9, 8'h00, 8'h10, 8'h10);  // R8 half
    apply(10, 8'h5A, 8'h00, 8'h90); // R9 keeps Z and C
    apply(10, 8'hFF, 8'h00, 8'h00); // R9
    apply(11, 8'h77, 8'h00, 8'h80); // R10 set carry
    apply(12, 8'h77, 8'h00, 8'hF0); // R10 toggle carry off
    apply(12, 8'h77, 8'h00, 8'h00); // R10 toggle carry on
    apply(13, 8'h11, 8'h22, 8'hFF); // R11
    apply(15, 8'h11, 8'h22, 8'h5A); // R11
    // random sweep, R12 covered across all codes
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 255));
    @(negedge clk);
    check_pending();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule